// File: doc/BRIEF.md
# Serial DAC control logic

This block is the digital front end of a single-channel 8-bit voltage-output converter. A host writes 16-bit command frames over a three-wire serial link made of an active-low select, a serial clock and a data line. The block takes the three wires into its own clock domain, assembles each frame and checks it. When the frame is well formed, the block decodes the 4-bit command in the top nibble and acts on it.

Two data registers form a double buffer. The input register holds a staged code. The DAC register drives the converter, and its value appears on `dac_code`. A power-mode machine has three states: normal, standby and shutdown. It drives an output-enable flag (low means the output stage is high impedance) and a reference-enable flag. A 2-bit reference-level select is written only by the three power-mode commands. The analog path and any wake-up delay lie outside this block.

Top module: `dac_ctl`

## Requirements
- R1: After reset `dac_code` is 0x00, `out_en` is 1 (normal mode), `ref_en` is 1 and `ref_sel` is 00.
- R2: Bits are taken on rising serial-clock edges only while `cs_n` is low, MSB first. Bits 15:12 carry the command, bits 11:4 the data and bits 3:0 the sub-bits. A frame executes when `cs_n` rises. Clock edges seen while `cs_n` is high have no effect.
- R3: Command 0001 writes the data to the input register and leaves `dac_code`, the mode and `ref_sel` unchanged.
- R4: Command 1000 copies the input register to `dac_code` and sets normal mode from any mode.
- R5: Commands 1001 and 1111 write the data to both registers, so `dac_code` takes the data, and they set normal mode from any mode.
- R6: Command 1100 gives standby (`out_en`=0, `ref_en`=1). Command 1101 gives normal (`out_en`=1, `ref_en`=1) with `dac_code` unchanged. Command 1110 gives shutdown (`out_en`=0, `ref_en`=0).
- R7: Commands 1100, 1101 and 1110 load `ref_sel` from data bits 7:6 (frame bits 11:10). No other command changes `ref_sel`.
- R8: Command 1100 received in shutdown leaves the block in shutdown. It still updates `ref_sel`.
- R9: Command 0000 and the reserved codes 0010 to 0111, 1010 and 1011 change neither register, the mode nor `ref_sel`.
- R10: A frame is discarded, with no state change, if `cs_n` rises after any count of clock edges other than 16, or if its sub-bits are not 0000.
- R11: Frames are accepted and executed in standby and in shutdown as well as in normal mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial frame select, active low |
| sclk | input | 1 | Serial bit clock |
| sdi | input | 1 | Serial data in |
| dac_code | output | 8 | Contents of the DAC register |
| out_en | output | 1 | Output stage enabled; low means high impedance |
| ref_en | output | 1 | Reference powered |
| ref_sel | output | 2 | Reference level select |

## Verification
The hardest state to reach is a standby request made while the block is in shutdown. To get there, the bench first sends a standby command and then a shutdown command, each carrying a different reference level. It then sends a standby command with a third level and checks that `ref_sel` changes while both enable flags stay low. The input register cannot be read at the ports. To check R3, R9 and R10, the bench follows each staging, ignored or malformed frame with a transfer command and compares the resulting `dac_code`. Malformed frames of 15 and 17 clock edges, and a frame with nonzero sub-bits, are sent between valid frames.

// File: rtl/dac_ctl_pkg.sv
package dac_ctl_pkg;
  localparam int CMD_W = 4;

  typedef enum logic [1:0] {
    PM_NORMAL   = 2'd0,
    PM_STANDBY  = 2'd1,
    PM_SHUTDOWN = 2'd2
  } pmode_e;

  localparam logic [CMD_W-1:0] OP_NOP     = 4'b0000;
  localparam logic [CMD_W-1:0] OP_STAGE   = 4'b0001;
  localparam logic [CMD_W-1:0] OP_XFER    = 4'b1000;
  localparam logic [CMD_W-1:0] OP_BOTH_A  = 4'b1001;
  localparam logic [CMD_W-1:0] OP_STBY    = 4'b1100;
  localparam logic [CMD_W-1:0] OP_WAKE    = 4'b1101;
  localparam logic [CMD_W-1:0] OP_SHDN    = 4'b1110;
  localparam logic [CMD_W-1:0] OP_BOTH_B  = 4'b1111;
endpackage

// File: rtl/dac_ctl_sync.sv
module dac_ctl_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic din;
      if (g == 0) begin : g_first
        assign din = d;
      end else begin : g_next
        assign din = chain_q[g-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain_q[g] <= RST_VAL;
        else        chain_q[g] <= din;
      end
    end
  endgenerate

  assign q = chain_q[STAGES-1];
endmodule

// File: rtl/dac_ctl_rx.sv
module dac_ctl_rx
  import dac_ctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int SUB_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_s,
  input  logic              sclk_s,
  input  logic              sdi_s,
  output logic              frm_vld,
  output logic [CMD_W-1:0]  frm_cmd,
  output logic [DATA_W-1:0] frm_data
);
  localparam int FRAME_W = CMD_W + DATA_W + SUB_W;
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);

  logic               sclk_d, cs_d;
  logic [FRAME_W-1:0] shift_q, shift_n;
  logic [CNT_W-1:0]   cnt_q, cnt_n;
  logic               vld_n;
  logic [CMD_W-1:0]   cmd_n;
  logic [DATA_W-1:0]  data_n;
  logic               sclk_rise, cs_rise, shift_en, cap_en;

  assign sclk_rise = sclk_s & ~sclk_d;
  assign cs_rise   = cs_s & ~cs_d;
  assign shift_en  = sclk_rise & ~cs_s;

  always_comb begin
    shift_n = shift_q;
    cnt_n   = cnt_q;
    vld_n   = 1'b0;
    cmd_n   = frm_cmd;
    data_n  = frm_data;
    cap_en  = 1'b0;
    if (cs_s) begin
      cnt_n = '0;
    end else if (sclk_rise) begin
      shift_n = {shift_q[FRAME_W-2:0], sdi_s};
      if (cnt_q != CNT_OVER) cnt_n = cnt_q + 1'b1;
    end
    if (cs_rise && (cnt_q == CNT_FULL) && (shift_q[SUB_W-1:0] == '0)) begin
      vld_n  = 1'b1;
      cap_en = 1'b1;
      cmd_n  = shift_q[FRAME_W-1 -: CMD_W];
      data_n = shift_q[SUB_W +: DATA_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d   <= 1'b0;
      cs_d     <= 1'b1;
      cnt_q    <= '0;
      shift_q  <= '0;
      frm_vld  <= 1'b0;
      frm_cmd  <= '0;
      frm_data <= '0;
    end else begin
      sclk_d  <= sclk_s;
      cs_d    <= cs_s;
      cnt_q   <= cnt_n;
      frm_vld <= vld_n;
      if (shift_en) shift_q <= shift_n;
      if (cap_en) begin
        frm_cmd  <= cmd_n;
        frm_data <= data_n;
      end
    end
  end
endmodule

// File: rtl/dac_ctl_regs.sv
module dac_ctl_regs
  import dac_ctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REF_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frm_vld,
  input  logic [CMD_W-1:0]  frm_cmd,
  input  logic [DATA_W-1:0] frm_data,
  output logic [DATA_W-1:0] dac_code,
  output logic              out_en,
  output logic              ref_en,
  output logic [REF_W-1:0]  ref_sel
);
  logic [DATA_W-1:0] in_q, in_n, dac_q, dac_n;
  logic [REF_W-1:0]  ref_q, ref_n;
  pmode_e            mode_q, mode_n;

  always_comb begin
    in_n   = in_q;
    dac_n  = dac_q;
    ref_n  = ref_q;
    mode_n = mode_q;
    if (frm_vld) begin
      case (frm_cmd)
        OP_STAGE: in_n = frm_data;
        OP_XFER: begin
          dac_n  = in_q;
          mode_n = PM_NORMAL;
        end
        OP_BOTH_A, OP_BOTH_B: begin
          in_n   = frm_data;
          dac_n  = frm_data;
          mode_n = PM_NORMAL;
        end
        OP_STBY: begin
          ref_n = frm_data[DATA_W-1 -: REF_W];
          if (mode_q == PM_NORMAL) mode_n = PM_STANDBY;
        end
        OP_WAKE: begin
          ref_n  = frm_data[DATA_W-1 -: REF_W];
          mode_n = PM_NORMAL;
        end
        OP_SHDN: begin
          ref_n  = frm_data[DATA_W-1 -: REF_W];
          mode_n = PM_SHUTDOWN;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      in_q   <= '0;
      dac_q  <= '0;
      ref_q  <= '0;
      mode_q <= PM_NORMAL;
    end else if (frm_vld) begin
      in_q   <= in_n;
      dac_q  <= dac_n;
      ref_q  <= ref_n;
      mode_q <= mode_n;
    end
  end

  assign dac_code = dac_q;
  assign ref_sel  = ref_q;
  assign out_en   = (mode_q == PM_NORMAL);
  assign ref_en   = (mode_q != PM_SHUTDOWN);
endmodule

// File: rtl/dac_ctl.sv
module dac_ctl
  import dac_ctl_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SUB_W       = 4,
  parameter int REF_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sclk,
  input  logic              sdi,
  output logic [DATA_W-1:0] dac_code,
  output logic              out_en,
  output logic              ref_en,
  output logic [REF_W-1:0]  ref_sel
);
  logic              cs_s, sclk_s, sdi_s;
  logic              frm_vld;
  logic [CMD_W-1:0]  frm_cmd;
  logic [DATA_W-1:0] frm_data;

  dac_ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_cs (
    .clk(clk), .rst_n(rst_n), .d(cs_n), .q(cs_s));
  dac_ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sclk (
    .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));
  dac_ctl_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sdi (
    .clk(clk), .rst_n(rst_n), .d(sdi), .q(sdi_s));

  dac_ctl_rx #(.DATA_W(DATA_W), .SUB_W(SUB_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_s(cs_s), .sclk_s(sclk_s), .sdi_s(sdi_s),
    .frm_vld(frm_vld), .frm_cmd(frm_cmd), .frm_data(frm_data));

  dac_ctl_regs #(.DATA_W(DATA_W), .REF_W(REF_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_cmd(frm_cmd),
    .frm_data(frm_data), .dac_code(dac_code), .out_en(out_en),
    .ref_en(ref_en), .ref_sel(ref_sel));
endmodule

// File: rtl/dac_ctl_chk.sv
module dac_ctl_chk
  import dac_ctl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int REF_W  = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              frm_vld,
  input logic [CMD_W-1:0]  frm_cmd,
  input logic [DATA_W-1:0] dac_code,
  input logic              out_en,
  input logic              ref_en,
  input logic [REF_W-1:0]  ref_sel
);
  logic rsvd_frame;
  logic mode_cmd;
  assign rsvd_frame = frm_vld && !(frm_cmd inside {OP_STAGE, OP_XFER, OP_BOTH_A,
                                   OP_BOTH_B, OP_STBY, OP_WAKE, OP_SHDN});
  assign mode_cmd = frm_vld && (frm_cmd inside {OP_STBY, OP_WAKE, OP_SHDN});

  // R3: the DAC code moves only when a decoded frame arrives
  a_r3_code_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !frm_vld |=> $stable(dac_code));

  // R4: transfer always ends in normal mode
  a_r4_xfer_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && frm_cmd == OP_XFER) |=> (out_en && ref_en));

  // R5: both-register loads always end in normal mode
  a_r5_load_wakes: assert property (@(posedge clk) disable iff (!rst_n)
    (frm_vld && (frm_cmd == OP_BOTH_A || frm_cmd == OP_BOTH_B)) |=> (out_en && ref_en));

  // R7: reference select changes only on power-mode commands
  a_r7_ref_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !mode_cmd |=> $stable(ref_sel));

  // R8: never shutdown straight to standby
  a_r8_no_shdn_to_stby: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_en && !ref_en) |=> !(!out_en && ref_en));

  // R9: reserved and no-op codes leave every output alone
  a_r9_rsvd_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    rsvd_frame |=> $stable({dac_code, out_en, ref_en, ref_sel}));
endmodule

bind dac_ctl dac_ctl_chk #(.DATA_W(DATA_W), .REF_W(REF_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .frm_vld(frm_vld), .frm_cmd(frm_cmd),
  .dac_code(dac_code), .out_en(out_en), .ref_en(ref_en), .ref_sel(ref_sel));

// File: tb/dac_ctl_test.sv
`timescale 1ns/1ps
module dac_ctl_test;
  typedef struct {
    logic [7:0] dac;
    logic       oe;
    logic       re;
    logic [1:0] rs;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n, cs_n, sclk, sdi;
  logic [7:0] dac_code;
  logic out_en, ref_en;
  logic [1:0] ref_sel;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  exp_t exp_q[$];
  event do_check;

  logic [7:0] m_in, m_dac;
  logic [1:0] m_rs;
  int         m_mode;  // 0 normal, 1 standby, 2 shutdown

  always #4 clk = ~clk;

  dac_ctl uut (.clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .sdi(sdi),
               .dac_code(dac_code), .out_en(out_en), .ref_en(ref_en), .ref_sel(ref_sel));

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // monitor: pops expectations and compares with the ports
  initial begin
    forever begin
      @(do_check);
      while (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        checks++;
        if (dac_code !== e.dac || out_en !== e.oe || ref_en !== e.re || ref_sel !== e.rs) begin
          fails++;
          $display("FAIL %s: got dac=%h oe=%b re=%b rs=%b, expected dac=%h oe=%b re=%b rs=%b",
                   e.tag, dac_code, out_en, ref_en, ref_sel, e.dac, e.oe, e.re, e.rs);
        end
      end
    end
  end

  task automatic push_expect(input string tag);
    exp_t e;
    e.dac = m_dac;
    e.oe  = (m_mode == 0);
    e.re  = (m_mode != 2);
    e.rs  = m_rs;
    e.tag = tag;
    @(negedge clk);
    exp_q.push_back(e);
    -> do_check;
    #1;
  endtask

  task automatic model(input logic [3:0] c, input logic [7:0] d);
    case (c)
      4'b0001: m_in = d;
      4'b1000: begin m_dac = m_in; m_mode = 0; end
      4'b1001, 4'b1111: begin m_in = d; m_dac = d; m_mode = 0; end
      4'b1100: begin m_rs = d[7:6]; if (m_mode == 0) m_mode = 1; end
      4'b1101: begin m_rs = d[7:6]; m_mode = 0; end
      4'b1110: begin m_rs = d[7:6]; m_mode = 2; end
      default: ;
    endcase
  endtask

  // driver: sends n bits (MSB first) of {c,d,s,0}, updates model, pushes expectation
  task automatic frame(input logic [3:0] c, input logic [7:0] d, input logic [3:0] s,
                       input int n, input string tag);
    logic [16:0] w;
    w = {c, d, s, 1'b0};
    cs_n = 1'b0;
    #40;
    for (int i = 0; i < n; i++) begin
      sdi = w[16-i];
      #40 sclk = 1'b1;
      #40 sclk = 1'b0;
    end
    #40 cs_n = 1'b1;
    repeat (16) @(posedge clk);
    if (n == 16 && s == 4'b0000) model(c, d);
    push_expect(tag);
    #100;
  endtask

  initial begin
    repeat (25000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout, expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cs_n = 1'b1; sclk = 1'b0; sdi = 1'b0;
    m_in = 8'h00; m_dac = 8'h00; m_rs = 2'b00; m_mode = 0;
    #50;
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(posedge clk);
    push_expect("R1 reset state");

    frame(4'b0001, 8'hA5, 4'h0, 16, "R3 stage leaves dac");
    frame(4'b1000, 8'h00, 4'h0, 16, "R4 transfer");
    frame(4'b1001, 8'h3C, 4'h0, 16, "R5 load both 1001");
    frame(4'b1111, 8'hC3, 4'h0, 16, "R5 load both 1111");
    frame(4'b1100, 8'h7F, 4'h0, 16, "R6 R7 standby ref 01");
    frame(4'b0001, 8'h77, 4'h0, 16, "R11 stage in standby");
    frame(4'b1101, 8'h80, 4'h0, 16, "R6 R7 wake ref 10");
    frame(4'b1110, 8'hC0, 4'h0, 16, "R6 R7 shutdown ref 11");
    frame(4'b1100, 8'h3F, 4'h0, 16, "R8 standby ignored in shutdown");
    frame(4'b1000, 8'h00, 4'h0, 16, "R4 R11 transfer wakes from shutdown");
    frame(4'b0000, 8'hFF, 4'h0, 16, "R9 nop");
    frame(4'b0101, 8'h11, 4'h0, 16, "R9 reserved 0101");
    frame(4'b1010, 8'h22, 4'h0, 16, "R9 reserved 1010");
    frame(4'b1011, 8'h33, 4'h0, 16, "R9 reserved 1011");
    frame(4'b0010, 8'h44, 4'h0, 16, "R9 reserved 0010");
    frame(4'b1000, 8'h00, 4'h0, 16, "R9 input register untouched");
    frame(4'b1001, 8'h12, 4'h0, 15, "R10 short frame");
    frame(4'b1001, 8'h34, 4'h0, 17, "R10 long frame");
    frame(4'b1001, 8'h56, 4'h1, 16, "R10 nonzero sub-bits");
    frame(4'b0001, 8'h9A, 4'h8, 16, "R10 bad stage");
    frame(4'b1000, 8'h00, 4'h0, 16, "R10 input register untouched");
    // clock edges with select high must not disturb the next frame
    sdi = 1'b1;
    for (int i = 0; i < 5; i++) begin
      #40 sclk = 1'b1;
      #40 sclk = 1'b0;
    end
    frame(4'b1001, 8'h5A, 4'h0, 16, "R2 edges while deselected ignored");
    frame(4'b1001, 8'hFF, 4'h0, 16, "R2 full scale");
    frame(4'b1001, 8'h00, 4'h0, 16, "R2 zero scale");
    frame(4'b1110, 8'h40, 4'h0, 16, "R6 shutdown ref 01");
    frame(4'b1111, 8'h81, 4'h0, 16, "R5 R7 load both wakes, ref kept");
    frame(4'b1100, 8'h00, 4'h0, 16, "R6 standby ref 00");
    frame(4'b1100, 8'hC0, 4'h0, 16, "R6 standby again ref 11");
    frame(4'b1001, 8'h18, 4'h0, 16, "R5 load both from standby");

    done = 1;
    summary();
    $finish;
  end
endmodule